// File: doc/BRIEF.md
# Reservation Station Pool with Operand Capture

This block holds a small pool of waiting slots that sit in front of one class of execution unit in an out-of-order core. The issue stage places an instruction into the lowest-numbered free slot. It supplies the opcode and, for each of the two sources, either the source value read from the register file or the tag of the slot that will produce that value. Since source values are copied into the slot when the instruction issues, a later overwrite of a source register cannot reach an instruction that has already issued.

A slot that still waits on a producer watches the result bus and copies the value whenever the tag on the bus equals the tag it holds. A value copied from the bus is not usable in the cycle it lands. One bypass cycle follows, and only after it can the slot request execution. When several slots are ready in the same cycle, the lowest-numbered one is sent, and each slot is sent only once. A slot stays occupied until its own result tag appears on the bus. The next issue can then use it. The issue stage reads the free indication and stalls while every slot is occupied.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free: `iss_ready` is 1, `iss_slot` is 0 and `disp_valid` is 0.
- R2: An issue with `iss_valid` high takes the slot that `iss_slot` names, which is the lowest-numbered free slot. That slot is then occupied from the next cycle on.
- R3: When both sources of an issue are not pending (`iss_*_pend` = 0), the slot asserts `disp_valid` in the cycle after the issue. It presents the issued opcode and both values on `disp_op`, `disp_j` and `disp_k`.
- R4: Source values are copied at issue. Changes on the issue value inputs while `iss_valid` is low do not alter a slot that has already issued.
- R5: Every waiting slot whose pending tag equals `cdb_tag` while `cdb_valid` is high captures `cdb_data` into that source. Two slots that wait on the same tag both capture it.
- R6: A source captured from the bus at a clock edge makes its slot ready only after one further edge. `disp_valid` stays low in the cycle after the broadcast and rises in the cycle after that.
- R7: A bus transfer whose tag matches no waiting source, or any tag presented with `cdb_valid` low, changes nothing.
- R8: When an issue names a pending tag that is on the bus in the same cycle, the slot takes the bus value at issue. It follows the same one-cycle bypass as in R6.
- R9: While all slots are occupied, `iss_ready` is 0 and an issue attempt is ignored. No slot is overwritten.
- R10: When several slots are ready, the lowest-numbered one is sent first. A slot asserts its dispatch request exactly once per issue.
- R11: A slot is freed by the edge at which its own tag (`BASE_TAG` + slot number) is on the bus with `cdb_valid` high after it has dispatched. A slot that has not yet dispatched ignores its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode to store |
| iss_j_pend | input | 1 | First source waits on a producer |
| iss_j_val | input | DATA_W | First source value when not pending |
| iss_j_tag | input | TAG_W | First source producer tag when pending |
| iss_k_pend | input | 1 | Second source waits on a producer |
| iss_k_val | input | DATA_W | Second source value when not pending |
| iss_k_tag | input | TAG_W | Second source producer tag when pending |
| iss_ready | output | 1 | At least one slot is free |
| iss_slot | output | SLOT_W | Slot the next issue will take |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the producing slot |
| cdb_data | input | DATA_W | Result value |
| disp_valid | output | 1 | A slot requests execution |
| disp_slot | output | SLOT_W | Slot being sent |
| disp_op | output | OP_W | Opcode of the sent slot |
| disp_j | output | DATA_W | First source value of the sent slot |
| disp_k | output | DATA_W | Second source value of the sent slot |

## Verification
A slot that misses a capture shows as a missing dispatch two cycles after the broadcast, and `disp_valid` then stays low for good. A slot that captures the wrong value, or lets a later issue overwrite it, is only visible when it dispatches, as a wrong value on `disp_j` or `disp_k`. The scoreboard therefore compares every dispatched field. A slot whose occupancy is stuck shows up on `iss_ready` and `iss_slot` in the first cycle after the freeing broadcast. A lost bypass delay shows as `disp_valid` rising one cycle early.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_HELD = 2'd1,
    ENT_SENT = 2'd2
  } ent_state_e;

  function automatic logic opnd_usable(input logic ok, input logic fresh);
    return ok && !fresh;
  endfunction

  function automatic logic tag_hit(input logic bus_v, input logic waiting,
                                   input logic [15:0] bus_tag, input logic [15:0] wait_tag);
    return bus_v && waiting && (bus_tag == wait_tag);
  endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter int              TAG_W  = 3,
  parameter int              OP_W   = 4,
  parameter logic [TAG_W-1:0] MY_TAG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   iss_op,
  input  logic              iss_j_pend,
  input  logic [DATA_W-1:0] iss_j_val,
  input  logic [TAG_W-1:0]  iss_j_tag,
  input  logic              iss_k_pend,
  input  logic [DATA_W-1:0] iss_k_val,
  input  logic [TAG_W-1:0]  iss_k_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              grant,
  output logic              busy,
  output logic              ready,
  output logic              cap,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  ent_state_e        st_q;
  logic [OP_W-1:0]   op_q;
  logic              j_ok, j_fr, k_ok, k_fr;
  logic [TAG_W-1:0]  j_tag, k_tag;
  logic [DATA_W-1:0] j_val, k_val;

  logic j_hit, k_hit, ji_hit, ki_hit, own_bcast;

  assign j_hit  = (st_q == ENT_HELD) &&
                  tag_hit(cdb_valid, !j_ok, 16'(cdb_tag), 16'(j_tag));
  assign k_hit  = (st_q == ENT_HELD) &&
                  tag_hit(cdb_valid, !k_ok, 16'(cdb_tag), 16'(k_tag));
  assign ji_hit = tag_hit(cdb_valid, iss_j_pend, 16'(cdb_tag), 16'(iss_j_tag));
  assign ki_hit = tag_hit(cdb_valid, iss_k_pend, 16'(cdb_tag), 16'(iss_k_tag));
  assign own_bcast = cdb_valid && (cdb_tag == MY_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ENT_FREE;
      op_q  <= '0;
      j_ok  <= 1'b0;
      j_fr  <= 1'b0;
      k_ok  <= 1'b0;
      k_fr  <= 1'b0;
      j_tag <= '0;
      k_tag <= '0;
      j_val <= '0;
      k_val <= '0;
    end else begin
      j_fr <= 1'b0;
      k_fr <= 1'b0;
      case (st_q)
        ENT_FREE: begin
          if (alloc) begin
            st_q  <= ENT_HELD;
            op_q  <= iss_op;
            j_ok  <= !iss_j_pend || ji_hit;
            j_fr  <= ji_hit;
            j_tag <= iss_j_tag;
            j_val <= iss_j_pend ? cdb_data : iss_j_val;
            k_ok  <= !iss_k_pend || ki_hit;
            k_fr  <= ki_hit;
            k_tag <= iss_k_tag;
            k_val <= iss_k_pend ? cdb_data : iss_k_val;
          end
        end
        ENT_HELD: begin
          if (j_hit) begin
            j_ok  <= 1'b1;
            j_fr  <= 1'b1;
            j_val <= cdb_data;
          end
          if (k_hit) begin
            k_ok  <= 1'b1;
            k_fr  <= 1'b1;
            k_val <= cdb_data;
          end
          if (grant) st_q <= ENT_SENT;
        end
        ENT_SENT: begin
          if (own_bcast) st_q <= ENT_FREE;
        end
        default: st_q <= ENT_FREE;
      endcase
    end
  end

  assign busy  = (st_q != ENT_FREE);
  assign ready = (st_q == ENT_HELD) && opnd_usable(j_ok, j_fr) && opnd_usable(k_ok, k_fr);
  assign cap   = j_hit || k_hit || (alloc && (st_q == ENT_FREE) && (ji_hit || ki_hit));
  assign op    = op_q;
  assign vj    = j_val;
  assign vk    = k_val;
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int NUM_ENT  = 2,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  parameter int OP_W     = 4,
  parameter int BASE_TAG = 2,
  localparam int SLOT_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic              iss_j_pend,
  input  logic [DATA_W-1:0] iss_j_val,
  input  logic [TAG_W-1:0]  iss_j_tag,
  input  logic              iss_k_pend,
  input  logic [DATA_W-1:0] iss_k_val,
  input  logic [TAG_W-1:0]  iss_k_tag,
  output logic              iss_ready,
  output logic [SLOT_W-1:0] iss_slot,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_slot,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_j,
  output logic [DATA_W-1:0] disp_k
);
  logic [NUM_ENT-1:0] busy_vec, free_vec, free_gnt, alloc_vec;
  logic [NUM_ENT-1:0] rdy_vec, grant_vec, cap_vec;
  logic [OP_W-1:0]    op_arr [NUM_ENT];
  logic [DATA_W-1:0]  vj_arr [NUM_ENT];
  logic [DATA_W-1:0]  vk_arr [NUM_ENT];

  assign free_vec  = ~busy_vec;
  assign alloc_vec = free_gnt & {NUM_ENT{iss_valid}};

  rs_pick #(.N(NUM_ENT), .IDX_W(SLOT_W)) u_free_pick (
    .req(free_vec), .gnt(free_gnt), .idx(iss_slot), .any(iss_ready)
  );

  rs_pick #(.N(NUM_ENT), .IDX_W(SLOT_W)) u_disp_pick (
    .req(rdy_vec), .gnt(grant_vec), .idx(disp_slot), .any(disp_valid)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    localparam logic [TAG_W-1:0] ENT_TAG = TAG_W'(BASE_TAG + g);
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .MY_TAG(ENT_TAG)) u_ent (
      .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[g]),
      .iss_op(iss_op),
      .iss_j_pend(iss_j_pend), .iss_j_val(iss_j_val), .iss_j_tag(iss_j_tag),
      .iss_k_pend(iss_k_pend), .iss_k_val(iss_k_val), .iss_k_tag(iss_k_tag),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .grant(grant_vec[g]),
      .busy(busy_vec[g]), .ready(rdy_vec[g]), .cap(cap_vec[g]),
      .op(op_arr[g]), .vj(vj_arr[g]), .vk(vk_arr[g])
    );
  end

  assign disp_op = op_arr[disp_slot];
  assign disp_j  = vj_arr[disp_slot];
  assign disp_k  = vk_arr[disp_slot];
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int NUM_ENT  = 2,
  parameter int TAG_W    = 3,
  parameter int BASE_TAG = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_valid,
  input logic               iss_ready,
  input logic [NUM_ENT-1:0] alloc_vec,
  input logic [NUM_ENT-1:0] busy_vec,
  input logic [NUM_ENT-1:0] rdy_vec,
  input logic [NUM_ENT-1:0] cap_vec,
  input logic [NUM_ENT-1:0] grant_vec,
  input logic               cdb_valid,
  input logic [TAG_W-1:0]   cdb_tag
);
  p_alloc_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  p_full_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> $countones(busy_vec) <= $countones($past(busy_vec)));

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_chk
    localparam logic [TAG_W-1:0] ENT_TAG = TAG_W'(BASE_TAG + g);

    p_alloc_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vec[g] |=> busy_vec[g]);

    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vec[g] |=> !rdy_vec[g]);

    p_sent_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vec[g] |=> !rdy_vec[g]);

    p_idle_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_vec[g] |-> !rdy_vec[g]);

    p_free_on_own_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_vec[g]) |-> $past(cdb_valid) && ($past(cdb_tag) == ENT_TAG));
  end
endmodule

bind rs_pool rs_pool_chk #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG)) i_rs_pool_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .alloc_vec(alloc_vec), .busy_vec(busy_vec), .rdy_vec(rdy_vec),
  .cap_vec(cap_vec), .grant_vec(grant_vec),
  .cdb_valid(cdb_valid), .cdb_tag(cdb_tag)
);

// File: tb/test_rs_pool.sv
module test_rs_pool;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_op = '0;
  logic        iss_j_pend = 1'b0, iss_k_pend = 1'b0;
  logic [31:0] iss_j_val = '0, iss_k_val = '0;
  logic [2:0]  iss_j_tag = '0, iss_k_tag = '0;
  logic        iss_ready;
  logic [0:0]  iss_slot;
  logic        cdb_valid = 1'b0;
  logic [2:0]  cdb_tag = '0;
  logic [31:0] cdb_data = '0;
  logic        disp_valid;
  logic [0:0]  disp_slot;
  logic [3:0]  disp_op;
  logic [31:0] disp_j, disp_k;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int     slot;
    int     op;
    longint j;
    longint k;
    string  req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rs_pool i_rs_pool (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_j_pend(iss_j_pend), .iss_j_val(iss_j_val), .iss_j_tag(iss_j_tag),
    .iss_k_pend(iss_k_pend), .iss_k_val(iss_k_val), .iss_k_tag(iss_k_tag),
    .iss_ready(iss_ready), .iss_slot(iss_slot),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_op(disp_op),
    .disp_j(disp_j), .disp_k(disp_k)
  );

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 1'b0;
    cdb_valid = 1'b0;
  endtask

  task automatic issue(input int op, input bit jp, input int jv, input int jt,
                       input bit kp, input int kv, input int kt);
    iss_valid  = 1'b1;
    iss_op     = 4'(op);
    iss_j_pend = jp;
    iss_j_val  = 32'(jv);
    iss_j_tag  = 3'(jt);
    iss_k_pend = kp;
    iss_k_val  = 32'(kv);
    iss_k_tag  = 3'(kt);
  endtask

  task automatic bcast(input int tag, input int data);
    cdb_valid = 1'b1;
    cdb_tag   = 3'(tag);
    cdb_data  = 32'(data);
  endtask

  task automatic expect_disp(input int slot, input int op, input longint j, input longint k,
                             input string rq);
    exp_t e;
    e.slot = slot; e.op = op; e.j = j; e.k = k; e.req = rq;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (exp_q.size() == 0) begin
        check("R10", "unexpected dispatch slot", longint'(disp_slot), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "disp_slot", longint'(disp_slot), e.slot);
        check(e.req, "disp_op",   longint'(disp_op),   e.op);
        check(e.req, "disp_j",    longint'(disp_j),    e.j);
        check(e.req, "disp_k",    longint'(disp_k),    e.k);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1", "iss_ready", iss_ready, 1);
    check("R1", "iss_slot", iss_slot, 0);
    check("R1", "disp_valid", disp_valid, 0);

    // R2 / R3: ready operands, dispatch next cycle
    issue(1, 0, 10, 0, 0, 20, 0);
    expect_disp(0, 1, 10, 20, "R3");
    step();
    idle();
    check("R3", "disp_valid after issue", disp_valid, 1);
    check("R2", "iss_slot next free", iss_slot, 1);
    step();
    check("R10", "disp_valid after single dispatch", disp_valid, 0);
    check("R11", "slot0 still held before own tag", iss_slot, 1);
    bcast(2, 0);
    step();
    idle();
    check("R11", "slot0 freed by own tag", iss_slot, 0);
    check("R11", "iss_ready after free", iss_ready, 1);

    // R4 R5 R6 R7 R9 R10: two slots wait on tag 6
    issue(2, 0, 5, 0, 1, 0, 6);
    step();
    issue(3, 1, 0, 6, 0, 7, 0);
    step();
    check("R9", "iss_ready when full", iss_ready, 0);
    issue(9, 0, 123, 0, 0, 456, 0);   // R9 attempt while full
    bcast(5, 111);                    // R7 wrong tag
    step();
    idle();
    iss_j_val = 32'd99;               // R4 later change of a source value
    iss_k_val = 32'd98;
    check("R7", "no dispatch on unmatched tag", disp_valid, 0);
    check("R9", "still full", iss_ready, 0);
    cdb_tag  = 3'd6;                  // R7 tag present but not valid
    cdb_data = 32'd55;
    step();
    check("R7", "no dispatch on invalid bus", disp_valid, 0);
    bcast(6, 42);
    expect_disp(0, 2, 5, 42, "R4");
    expect_disp(1, 3, 42, 7, "R5");
    step();
    idle();
    check("R6", "bypass cycle holds dispatch", disp_valid, 0);
    step();
    check("R6", "dispatch after bypass", disp_valid, 1);
    check("R10", "lowest slot first", disp_slot, 0);
    step();
    check("R10", "second slot next", disp_slot, 1);
    step();
    check("R10", "no repeat dispatch", disp_valid, 0);
    bcast(2, 0);
    step();
    bcast(3, 0);
    step();
    idle();
    check("R11", "both freed", iss_ready, 1);
    check("R11", "lowest free slot", iss_slot, 0);

    // R8: issue while the named tag is on the bus
    issue(4, 1, 0, 5, 0, 1, 0);
    bcast(5, 77);
    expect_disp(0, 4, 77, 1, "R8");
    step();
    idle();
    check("R8", "bypass after issue capture", disp_valid, 0);
    step();
    check("R8", "dispatch after bypass", disp_valid, 1);
    step();
    bcast(2, 0);
    step();
    idle();
    step();

    check("R5", "scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule